// File: doc/BRIEF.md
# Registered Read-Only Memory with Dual Output Enables

This block is a 1024 x 8 read-only store whose read data passes through an edge-triggered output register. The word is computed from the address, so no memory array is instantiated. On every rising clock edge, the word at the current address is latched. The output then holds steady until the next edge, whatever the address does in between. A system can therefore present the next address while the previous word is still being consumed.

Two enables decide whether the output drives.

- **Clocked enable.** It is active low and is sampled into a flip-flop. Reset sets that flip-flop to its disabled state.
- **Immediate enable.** It is active low and takes effect with no clock.

An active-low initialize input loads a separately chosen initialize word into the data register at once. It does not wait for a clock. This makes it useful as a power-up or time-out start value. The high-impedance state is modelled by a drive flag, and the data bus reads zero whenever the flag is false.

Top module: `regrom_dual_en`

## Requirements
- R1: While reset is low, and after reset until the first rising edge that samples the clocked enable low, the drive flag is 0 and the data bus is 0.
- R2: A rising edge with initialize high latches word(a) for the address a present at that edge. Here word(a) = a[7:0] XOR {6'b0, a[9:8]} XOR KEY, and KEY defaults to 8'hA5. The word is visible on the bus after that edge when the drive flag is 1.
- R3: Between rising edges the data bus does not change when the address changes.
- R4: A rising edge that samples the clocked enable high makes the drive flag 0 after that edge, whatever the immediate enable is.
- R5: A rising edge that samples the clocked enable low sets the clocked enable state to enabled. From then on, the drive flag equals NOT immediate-enable.
- R6: The immediate enable acts without a clock. High forces the drive flag to 0 at once. Low restores drive at once if the clocked state is enabled.
- R7: Initialize low loads INIT_WORD into the data register at once, in mid-cycle if that is when it falls. INIT_WORD defaults to 8'h00, which acts as a clear.
- R8: While initialize stays low, clock edges do not change the register. After initialize rises, the register holds INIT_WORD until the first rising edge, which loads word(address) again.
- R9: Whenever the drive flag is 0, the data bus reads 8'h00. A loaded initialize word appears only while both enables permit drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge latches data and the clocked enable |
| rst_n | input | 1 | Active-low asynchronous reset of the clocked-enable flip-flop (disabled state) |
| addr | input | 10 | Word address |
| sen_n | input | 1 | Active-low clocked output enable |
| aen_n | input | 1 | Active-low immediate output enable |
| init_n | input | 1 | Active-low asynchronous load of the initialize word |
| dout | output | 8 | Registered data, 0 when not driving |
| drive | output | 1 | High when the output would drive; low models high impedance |

## Verification
The bench targets the hazards around the enables and the register.

- **Power-up drive.** It checks that no drive appears before the first enabling clock edge. A flip-flop that resets to the enabled state would drive early.
- **Address changes mid-cycle.** A combinational read path would let the bus follow the address instead of holding the latched word.
- **Enable ordering.** Both enables are toggled in both orders. An unregistered clocked enable, or an immediate enable that waited for a clock, shows up as drive in the wrong cycle.
- **Initialize timing.** The initialize input is pulsed mid-cycle, held across an edge and released. An implementation that synchronised it, or let an edge overwrite it, would show the wrong word.

// File: rtl/regrom_dual_en.sv
module regrom_dual_en #(
  parameter int          AW        = 10,
  parameter int          DW        = 8,
  parameter logic [DW-1:0] ROM_KEY   = 8'hA5,
  parameter logic [DW-1:0] INIT_WORD = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          sen_n,
  input  logic          aen_n,
  input  logic          init_n,
  output logic [DW-1:0] dout,
  output logic          drive
);

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = ROM_KEY;
    for (int i = 0; i < AW; i++) w[i % DW] = w[i % DW] ^ a[i];
    return w;
  endfunction

  logic [DW-1:0] data_q;
  logic          sen_q;

  always_ff @(posedge clk or negedge init_n)
    if (!init_n) data_q <= INIT_WORD;
    else         data_q <= rom_word(addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sen_q <= 1'b1;
    else        sen_q <= sen_n;

  assign drive = !sen_q && !aen_n;
  assign dout  = drive ? data_q : '0;

  a_r4_sync_disable: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n |=> !drive);

  a_r5_sync_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_n |=> (drive == !aen_n));

  a_r7_init_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> data_q == INIT_WORD);

  a_r8_init_held_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_n) |-> data_q == INIT_WORD);

  a_r1_reset_no_drive: assert property (@(posedge clk)
    !rst_n |=> !drive);

endmodule

// File: tb/tb_regrom_dual_en.sv
module tb_regrom_dual_en;
  localparam logic [7:0] KEY  = 8'hA5;
  localparam logic [7:0] IWRD = 8'h3C;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [9:0] addr = '0;
  logic       sen_n = 1, aen_n = 1, init_n = 1;
  logic [7:0] dout;
  logic       drive;

  int total = 0, bad = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  event       ev;

  regrom_dual_en #(.AW(10), .DW(8), .ROM_KEY(KEY), .INIT_WORD(IWRD)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sen_n(sen_n), .aen_n(aen_n),
    .init_n(init_n), .dout(dout), .drive(drive));

  always #10 clk = ~clk;

  function automatic logic [7:0] word(input logic [9:0] a);
    return a[7:0] ^ {6'b0, a[9:8]} ^ KEY;
  endfunction

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic expect_out(input logic de, input logic [7:0] d, input string tag);
    exp_q.push_back({de, d});
    tag_q.push_back(tag);
    ->ev;
    #2;
  endtask

  initial forever begin
    @(ev); #1;
    while (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({drive, dout} !== e) begin
        bad++;
        $display("FAIL %s: drive/dout actual=%b/%h expected=%b/%h", t, drive, dout, e[8], e[7:0]);
      end
    end
  end

  initial begin
    #1;
    expect_out(0, 8'h00, "R1 in reset");
    tick(); tick();
    rst_n = 1;
    tick();
    expect_out(0, 8'h00, "R1 after reset, enable high");
    sen_n = 0; aen_n = 0; addr = 10'd5;
    expect_out(0, 8'h00, "R1 no drive before enabling edge");
    tick();
    expect_out(1, word(10'd5), "R2 first read");
    addr = 10'h3FF;
    expect_out(1, word(10'd5), "R3 stable on address change");
    tick();
    expect_out(1, word(10'h3FF), "R2 read 3FF");
    addr = 10'h200;
    tick();
    expect_out(1, word(10'h200), "R2 read 200");
    aen_n = 1;
    expect_out(0, 8'h00, "R6 immediate disable / R9");
    aen_n = 0;
    expect_out(1, word(10'h200), "R6 immediate re-enable");
    sen_n = 1; addr = 10'h0A1;
    tick();
    expect_out(0, 8'h00, "R4 clocked disable");
    aen_n = 1; #3; aen_n = 0;
    expect_out(0, 8'h00, "R4 immediate enable cannot override");
    sen_n = 0;
    tick();
    expect_out(1, word(10'h0A1), "R5 clocked re-enable");
    aen_n = 1;
    expect_out(0, 8'h00, "R6 immediate first");
    sen_n = 1;
    tick();
    expect_out(0, 8'h00, "R4 both disabled");
    sen_n = 0; addr = 10'h155;
    tick();
    expect_out(0, 8'h00, "R5 clocked on, immediate still off");
    aen_n = 0;
    expect_out(1, word(10'h155), "R6 immediate enable completes");
    init_n = 0;
    expect_out(1, IWRD, "R7 mid-cycle initialize");
    addr = 10'h077;
    tick();
    expect_out(1, IWRD, "R8 edge ignored while initialize low");
    init_n = 1;
    expect_out(1, IWRD, "R8 held after release");
    tick();
    expect_out(1, word(10'h077), "R8 resumes at first edge");
    aen_n = 1; init_n = 0;
    expect_out(0, 8'h00, "R9 initialize hidden while disabled");
    aen_n = 0;
    expect_out(1, IWRD, "R7 initialize shown when enabled");
    init_n = 1;
    tick();
    rst_n = 0;
    expect_out(0, 8'h00, "R1 reset reasserted");
    #5;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule